// File: doc/BRIEF.md
# CRC-Guarded I2C Register Target

This block is an I2C target that gives a controller on the bus access to a bank of 8-bit registers. A write transfer sets an 8-bit register pointer and then delivers a data byte. A read transfer first sets the pointer with a write, then uses a repeated START and the read address. The block does not hold the registers itself. It drives a simple register-file port, which has a combinational read-data input and a one-cycle write strobe.

A configuration input turns on a CRC mode. In CRC mode every data byte on the bus is followed by a CRC-8 byte. The CRC covers three bytes: the device byte (the 7-bit address, shifted left, with R/W in bit 0), the register pointer and the data byte. On a write, the target compares the received CRC byte with its own result. The register file is updated only when the two match. On a mismatch the CRC byte is NACKed and a sticky error flag is raised. On a read, the target sends the register value and then the CRC it computed over that value.

The bus lines are sampled with the system clock through synchronisers. SDA is driven only low, through an open-drain enable.

Top module: `i2c_crc_target`

## Requirements
- R1: The CRC is CRC-8 with polynomial 0x1D and start value 0xFF. Bits are taken most significant first and there is no final XOR. The input is the device byte (address<<1 | R/W), then the register byte, then the data byte.
- R2: The device byte is ACKed only when its upper seven bits equal DEV_ADDR. For any other address the block NACKs, drives nothing and writes nothing until the next START.
- R3: With crc_mode low, a write carries exactly one data byte after the register byte. That byte is ACKed and committed by a single one-cycle rf_we pulse, with rf_addr equal to the register byte and rf_wdata equal to the data byte. Any further byte in the same transfer is NACKed and not written.
- R4: With crc_mode high, a write sends the data byte and then a CRC byte. The write is committed, and the CRC byte ACKed, only when the CRC byte equals the R1 CRC with R/W = 0.
- R5: A CRC byte that does not match is NACKed and produces no rf_we pulse. crc_err goes to 1 and stays at 1 until reset.
- R6: A register byte above MAX_REG (default 0x82) is NACKed. The pointer keeps its old value and nothing is written. 0x82 itself is accepted.
- R7: With crc_mode low, a read returns the register at the pointer, most significant bit first, as one byte.
- R8: With crc_mode high, a read returns the register byte and then the R1 CRC with R/W = 1, provided the controller ACKs the data byte.
- R9: After reset, sda_oe, rf_we and crc_err are 0 and the pointer is 0. A read with no prior pointer write therefore returns register 0.
- R10: A STOP, or a new START, abandons a transfer at any point. A CRC-mode write stopped before its CRC byte commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| crc_mode | input | 1 | 1 selects CRC-guarded transfers |
| rf_we | output | 1 | One-cycle write strobe to the register file |
| rf_addr | output | 8 | Register pointer, for both read and write |
| rf_wdata | output | 8 | Write data for the register file |
| rf_rdata | input | 8 | Combinational read data at rf_addr |
| crc_err | output | 1 | Sticky flag: a write CRC mismatch was seen |

## Verification
Two decisions fall on the same SCL falling edge, the one that closes the CRC byte of a write: the commit or discard of the write, and the ACK or NACK driven onto SDA. The bench sends writes whose CRC byte is correct and writes whose CRC byte has one bit flipped. For each, it judges the ACK bit, whether the bench's register model changed, and whether crc_err rose. A second case places a STOP where the CRC byte should start. This checks that deferring the commit to the CRC byte leaves nothing written.

// File: rtl/i2c_crc_pkg.sv
package i2c_crc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_TXACK,
        S_WAIT
    } bus_st_e;

    // which byte of the transfer the shifter is working on
    typedef enum logic [2:0] {
        P_DEV,
        P_REG,
        P_DAT,
        P_CRC,
        P_OVER,
        P_TXD,
        P_TXC
    } phase_e;

    localparam logic [7:0] CRC_POLY = 8'h1D;
    localparam logic [7:0] CRC_SEED = 8'hFF;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t cq, nx;

    logic scl_now;
    logic sda_now;

    assign scl_now = cq.scl_sh[STAGES-1];
    assign sda_now = cq.sda_sh[STAGES-1];

    always_comb begin
        nx          = cq;
        nx.scl_sh   = {cq.scl_sh[STAGES-2:0], scl_i};
        nx.sda_sh   = {cq.sda_sh[STAGES-2:0], sda_i};
        nx.scl_prev = scl_now;
        nx.sda_prev = sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq <= '1;
        end else begin
            cq <= nx;
        end
    end

    assign sda_lvl   = sda_now;
    assign scl_rise  = scl_now & ~cq.scl_prev;
    assign scl_fall  = ~scl_now & cq.scl_prev;
    assign start_det = scl_now & cq.scl_prev & cq.sda_prev & ~sda_now;
    assign stop_det  = scl_now & cq.scl_prev & ~cq.sda_prev & sda_now;

endmodule

// File: rtl/crc8_byte.sv
module crc8_byte #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   POLY = 'h1D
) (
    input  logic [W-1:0] seed,
    input  logic [W-1:0] data,
    output logic [W-1:0] result
);

    logic [W-1:0] stage [0:W];

    assign stage[0] = seed ^ data;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign stage[i+1] = stage[i][W-1] ? ({stage[i][W-2:0], 1'b0} ^ POLY)
                                          :  {stage[i][W-2:0], 1'b0};
    end

    assign result = stage[W];

endmodule

// File: rtl/i2c_crc_target.sv
module i2c_crc_target
    import i2c_crc_pkg::*;
#(
    parameter int         W           = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h08,
    parameter logic [7:0] MAX_REG     = 8'h82,
    parameter int         SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scl_i,
    input  logic         sda_i,
    output logic         sda_oe,
    input  logic         crc_mode,
    output logic         rf_we,
    output logic [W-1:0] rf_addr,
    output logic [W-1:0] rf_wdata,
    input  logic [W-1:0] rf_rdata,
    output logic         crc_err
);

    localparam int            CW       = $clog2(W + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(W);
    localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

    typedef struct packed {
        bus_st_e       st;
        phase_e        ph;
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
        logic          ack;
        logic          oe;
        logic [W-1:0]  ptr;
        logic [W-1:0]  wdat;
        logic          we;
        logic [W-1:0]  crc;
        logic          err;
    } tgt_t;

    tgt_t cq, nx;

    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    // unit A folds one byte into the running CRC; unit B then folds in the pointer
    logic [W-1:0] crc_seed_a, crc_data_a, crc_a, crc_b;

    assign crc_seed_a = (cq.ph == P_DEV) ? W'(CRC_SEED) : cq.crc;
    assign crc_data_a = (cq.st == S_ACK) ? rf_rdata : cq.sh;

    crc8_byte #(.W(W), .POLY(W'(CRC_POLY))) u_crc_a (
        .seed  (crc_seed_a),
        .data  (crc_data_a),
        .result(crc_a)
    );

    crc8_byte #(.W(W), .POLY(W'(CRC_POLY))) u_crc_b (
        .seed  (crc_a),
        .data  (cq.ptr),
        .result(crc_b)
    );

    always_comb begin
        nx    = cq;
        nx.we = 1'b0;
        if (stop_det) begin
            nx.st = S_IDLE;
            nx.oe = 1'b0;
        end else if (start_det) begin
            nx.st  = S_RX;
            nx.ph  = P_DEV;
            nx.cnt = '0;
            nx.oe  = 1'b0;
        end else begin
            case (cq.st)
                S_RX: begin
                    if (scl_rise && cq.cnt < CNT_FULL) begin
                        nx.sh  = {cq.sh[W-2:0], sda_lvl};
                        nx.cnt = cq.cnt + CW'(1);
                    end else if (scl_fall && cq.cnt == CNT_FULL) begin
                        nx.st  = S_ACK;
                        nx.ack = 1'b0;
                        case (cq.ph)
                            P_DEV: begin
                                if (cq.sh[W-1:1] == DEV_ADDR) begin
                                    nx.ack = 1'b1;
                                    nx.ph  = cq.sh[0] ? P_TXD : P_REG;
                                    nx.crc = cq.sh[0] ? crc_b : crc_a;
                                end
                            end
                            P_REG: begin
                                if (cq.sh <= MAX_REG) begin
                                    nx.ack = 1'b1;
                                    nx.ptr = cq.sh;
                                    nx.crc = crc_a;
                                    nx.ph  = P_DAT;
                                end
                            end
                            P_DAT: begin
                                nx.ack  = 1'b1;
                                nx.crc  = crc_a;
                                nx.wdat = cq.sh;
                                if (crc_mode) begin
                                    nx.ph = P_CRC;
                                end else begin
                                    nx.we = 1'b1;
                                    nx.ph = P_OVER;
                                end
                            end
                            P_CRC: begin
                                if (cq.sh == cq.crc) begin
                                    nx.ack = 1'b1;
                                    nx.we  = 1'b1;
                                    nx.ph  = P_OVER;
                                end else begin
                                    nx.err = 1'b1;
                                end
                            end
                            default: nx.ack = 1'b0;
                        endcase
                        nx.oe = nx.ack;
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        nx.oe = 1'b0;
                        if (!cq.ack) begin
                            nx.st = S_WAIT;
                        end else if (cq.ph == P_TXD) begin
                            nx.sh  = rf_rdata;
                            nx.crc = crc_a;
                            nx.cnt = '0;
                            nx.oe  = ~rf_rdata[W-1];
                            nx.st  = S_TX;
                        end else begin
                            nx.cnt = '0;
                            nx.st  = S_RX;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (cq.cnt == CNT_LAST) begin
                            nx.oe = 1'b0;
                            nx.st = S_TXACK;
                        end else begin
                            nx.sh  = {cq.sh[W-2:0], 1'b0};
                            nx.cnt = cq.cnt + CW'(1);
                            nx.oe  = ~cq.sh[W-2];
                        end
                    end
                end
                S_TXACK: begin
                    if (scl_rise) begin
                        nx.ack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (cq.ack && cq.ph == P_TXD && crc_mode) begin
                            nx.ph  = P_TXC;
                            nx.sh  = cq.crc;
                            nx.cnt = '0;
                            nx.oe  = ~cq.crc[W-1];
                            nx.st  = S_TX;
                        end else begin
                            nx.st = S_WAIT;
                        end
                    end
                end
                default: nx.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq      <= '0;
            cq.st   <= S_IDLE;
            cq.ph   <= P_DEV;
            cq.crc  <= W'(CRC_SEED);
        end else begin
            cq <= nx;
        end
    end

    assign sda_oe   = cq.oe;
    assign rf_we    = cq.we;
    assign rf_addr  = cq.ptr;
    assign rf_wdata = cq.wdat;
    assign crc_err  = cq.err;

    // R3: a commit is exactly one clock wide
    p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    // R6: no commit can target a register beyond the map
    p_commit_in_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_addr <= MAX_REG));

    // R5: the error flag never falls back without reset
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |=> crc_err);

    // R5: the edge that raises the flag carries neither a write nor an ACK
    p_err_no_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> (!rf_we && !sda_oe));

    // R10: a STOP always leaves SDA released and no commit pending
    p_stop_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && !rf_we));

endmodule

// File: tb/test_i2c_crc_target.sv
module test_i2c_crc_target;

    localparam int         Q     = 10;
    localparam logic [6:0] DEV   = 7'h08;
    localparam logic [6:0] OTHER = 7'h09;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       crc_mode = 1'b0;
    logic       rf_we;
    logic [7:0] rf_addr, rf_wdata, rf_rdata;
    logic       crc_err;

    int n_tests = 0;
    int n_fail  = 0;
    int wr_cnt  = 0;

    logic [7:0] mem     [0:255];
    logic [7:0] exp_mem [0:255];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rf_rdata = mem[rf_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else if (rf_we) begin
            mem[rf_addr] <= rf_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    i2c_crc_target i_i2c_crc_target (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .crc_mode(crc_mode),
        .rf_we   (rf_we),
        .rf_addr (rf_addr),
        .rf_wdata(rf_wdata),
        .rf_rdata(rf_rdata),
        .crc_err (crc_err)
    );

    // bit-serial reference of the R1 CRC over a 24-bit packet
    function automatic logic [7:0] ref_crc(input logic [23:0] pkt);
        logic [7:0] c;
        logic       fb;
        c = 8'hFF;
        for (int k = 23; k >= 0; k--) begin
            fb = c[7] ^ pkt[k];
            c  = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic hc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hc(Q);
        scl_m = 1'b1; hc(Q);
        sda_m = 1'b0; hc(Q);
        scl_m = 1'b0; hc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hc(Q);
        scl_m = 1'b1; hc(Q);
        sda_m = 1'b1; hc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int k = 7; k >= 0; k--) begin
            sda_m = b[k]; hc(Q);
            scl_m = 1'b1; hc(2 * Q);
            scl_m = 1'b0; hc(Q);
        end
        sda_m = 1'b1; hc(Q);
        scl_m = 1'b1; hc(Q);
        ack = ~sda_line; hc(Q);
        scl_m = 1'b0; hc(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        sda_m = 1'b1;
        for (int k = 7; k >= 0; k--) begin
            hc(Q);
            scl_m = 1'b1; hc(Q);
            b[k] = sda_line; hc(Q);
            scl_m = 1'b0;
        end
        hc(1);
        sda_m = mack ? 1'b0 : 1'b1; hc(Q);
        scl_m = 1'b1; hc(2 * Q);
        scl_m = 1'b0; hc(Q);
        sda_m = 1'b1;
    endtask

    task automatic write_txn(input logic [6:0] dev, input logic [7:0] rg, input logic [7:0] dat,
                             input logic send_crc, input logic [7:0] cb,
                             output logic a_dev, output logic a_reg,
                             output logic a_dat, output logic a_crc);
        bus_start();
        send_byte({dev, 1'b0}, a_dev);
        send_byte(rg, a_reg);
        send_byte(dat, a_dat);
        a_crc = 1'b0;
        if (send_crc) send_byte(cb, a_crc);
        bus_stop();
    endtask

    task automatic read_txn(input logic [7:0] rg, output logic [7:0] d, output logic [7:0] c,
                            output logic a_reg, output logic a_rd);
        logic a0;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(rg, a_reg);
        bus_start();
        send_byte({DEV, 1'b1}, a_rd);
        c = 8'h00;
        if (crc_mode) begin
            recv_byte(d, 1'b1);
            recv_byte(c, 1'b0);
        end else begin
            recv_byte(d, 1'b0);
        end
        bus_stop();
    endtask

    typedef struct packed {
        logic       crc_on;
        logic       bad;
        logic [7:0] rg;
        logic [7:0] dat;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'h10, 8'hA5},
        '{1'b0, 1'b0, 8'h82, 8'h3C},
        '{1'b1, 1'b0, 8'h00, 8'h7E},
        '{1'b1, 1'b0, 8'h45, 8'hC3},
        '{1'b1, 1'b1, 8'h45, 8'h11},
        '{1'b0, 1'b0, 8'h46, 8'h11},
        '{1'b1, 1'b0, 8'h81, 8'hFF},
        '{1'b1, 1'b0, 8'h20, 8'h00}
    };

    initial begin
        logic       ad, ar, adt, ac, ard;
        logic [7:0] d, c, good;
        logic       err_exp;
        int         w0;

        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'h5A;
        err_exp = 1'b0;
        hc(5);
        rst_n = 1'b1;
        hc(5);

        // reset state
        chk("R9 sda_oe after reset", 16'(sda_oe), 16'h0);
        chk("R9 rf_we after reset", 16'(rf_we), 16'h0);
        chk("R9 crc_err after reset", 16'(crc_err), 16'h0);

        // read with pointer untouched since reset
        bus_start();
        send_byte({DEV, 1'b1}, ard);
        recv_byte(d, 1'b0);
        bus_stop();
        chk("R9 read ack at reset pointer", 16'(ard), 16'h1);
        chk("R9 pointer starts at 0", 16'(d), 16'(exp_mem[0]));

        // table-driven writes and readbacks
        for (int i = 0; i < NV; i++) begin
            crc_mode = VECS[i].crc_on;
            w0   = wr_cnt;
            good = ref_crc({DEV, 1'b0, VECS[i].rg, VECS[i].dat});
            write_txn(DEV, VECS[i].rg, VECS[i].dat, VECS[i].crc_on,
                      VECS[i].bad ? (good ^ 8'h01) : good, ad, ar, adt, ac);
            hc(2);
            chk("R2 own address ACK", 16'(ad), 16'h1);
            chk("R6 in-map register ACK", 16'(ar), 16'h1);
            chk("R3 data byte ACK", 16'(adt), 16'h1);
            if (VECS[i].crc_on && !VECS[i].bad) begin
                chk("R4 good CRC ACK", 16'(ac), 16'h1);
                exp_mem[VECS[i].rg] = VECS[i].dat;
            end else if (VECS[i].bad) begin
                chk("R5 bad CRC NACK", 16'(ac), 16'h0);
                err_exp = 1'b1;
            end else begin
                exp_mem[VECS[i].rg] = VECS[i].dat;
            end
            chk(VECS[i].bad ? "R5 write count after bad CRC" : "R3 one commit per write",
                16'(wr_cnt - w0), VECS[i].bad ? 16'h0 : 16'h1);
            chk(VECS[i].crc_on ? "R4 register content" : "R3 register content",
                16'(mem[VECS[i].rg]), 16'(exp_mem[VECS[i].rg]));
            chk("R5 crc_err flag", 16'(crc_err), 16'(err_exp));

            read_txn(VECS[i].rg, d, c, ar, ard);
            chk("R2 read address ACK", 16'(ard), 16'h1);
            chk(VECS[i].crc_on ? "R8 read data" : "R7 read data",
                16'(d), 16'(exp_mem[VECS[i].rg]));
            if (VECS[i].crc_on)
                chk("R8 R1 read CRC", 16'(c),
                    16'(ref_crc({DEV, 1'b1, VECS[i].rg, exp_mem[VECS[i].rg]})));
        end

        // foreign address is ignored
        crc_mode = 1'b0;
        w0 = wr_cnt;
        write_txn(OTHER, 8'h10, 8'h99, 1'b0, 8'h00, ad, ar, adt, ac);
        hc(2);
        chk("R2 foreign address NACK", 16'(ad), 16'h0);
        chk("R2 foreign register byte not ACKed", 16'(ar), 16'h0);
        chk("R2 foreign write ignored", 16'(wr_cnt - w0), 16'h0);

        // register beyond the map, pointer left at 0x20 by the last vector
        w0 = wr_cnt;
        write_txn(DEV, 8'h83, 8'h55, 1'b0, 8'h00, ad, ar, adt, ac);
        hc(2);
        chk("R6 register 0x83 NACK", 16'(ar), 16'h0);
        chk("R6 data after bad register NACK", 16'(adt), 16'h0);
        chk("R6 no write for bad register", 16'(wr_cnt - w0), 16'h0);
        bus_start();
        send_byte({DEV, 1'b1}, ard);
        recv_byte(d, 1'b0);
        bus_stop();
        chk("R6 pointer unchanged", 16'(d), 16'(exp_mem[8'h20]));

        // extra byte with CRC off
        w0 = wr_cnt;
        write_txn(DEV, 8'h30, 8'h6B, 1'b1, 8'hE7, ad, ar, adt, ac);
        hc(2);
        exp_mem[8'h30] = 8'h6B;
        chk("R3 extra byte NACK", 16'(ac), 16'h0);
        chk("R3 extra byte not written", 16'(mem[8'h30]), 16'h6B);
        chk("R3 single commit with extra byte", 16'(wr_cnt - w0), 16'h1);

        // CRC-mode write stopped before its CRC byte
        crc_mode = 1'b1;
        w0 = wr_cnt;
        write_txn(DEV, 8'h31, 8'hD2, 1'b0, 8'h00, ad, ar, adt, ac);
        hc(2);
        chk("R10 aborted write ACKs data", 16'(adt), 16'h1);
        chk("R10 aborted write commits nothing", 16'(wr_cnt - w0), 16'h0);
        chk("R10 aborted register unchanged", 16'(mem[8'h31]), 16'(exp_mem[8'h31]));
        chk("R10 sda released after stop", 16'(sda_oe), 16'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule